// File: doc/BRIEF.md
# Password Retry Lockout Controller

This block keeps count of failed password attempts and decides, from that count, which kinds of access remain open. An 8-bit failure counter is compared against an 8-bit limit register. While counting is enabled and the two are equal, the block locks out access. The lockout is either total or leaves configuration operations available, depending on two bits of the configuration byte.

The surrounding logic compares passwords and handles the serial bus. It pulses `attempt_i` once per password attempt and gives the outcome on `pass_ok_i`. It reads the two grant outputs to decide whether to continue. In configuration mode it may rewrite the counter and the limit through the write ports.

The counter wraps modulo 256 rather than saturating. If software leaves the counter above the limit, many more failures are allowed before the lockout returns.

Top module: `retry_lockout`

## Requirements
- R1: Reset clears both the counter and the limit register to 0. With counting enabled, the block is therefore at its limit straight after reset.
- R2: The configuration byte decodes as follows. Bit 7 is UA1, bit 6 is UA2, bit 3 is clear-on-pass and bit 2 is count-enable. Bits 5, 4, 1 and 0 have no effect on any output.
- R3: With count-enable at 0, both grants are high and attempts leave the counter unchanged.
- R4: With count-enable at 1 and the counter not equal to the limit, both grants are high.
- R5: With count-enable at 1, counter equal to limit, and UA1,UA2 = 1,0, both grants are low.
- R6: With count-enable at 1, counter equal to limit, and any other UA1,UA2 value, only the configuration grant is high.
- R7: An attempt with a wrong password that is not blocked raises the counter by one at the next clock edge, wrapping from 255 to 0.
- R8: A correct, unblocked attempt clears the counter when clear-on-pass is 1. It leaves the counter unchanged when clear-on-pass is 0.
- R9: The limit check is made when the attempt arrives, before its outcome is applied. An attempt made at the limit changes the counter in neither direction.
- R10: Writes to the counter and to the limit take effect at the next clock edge. A counter write in the same cycle as an attempt wins over the attempt.
- R11: With the counter above the limit, exactly 256 − (counter − limit) further failures are needed to reach the lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte_i | input | 8 | Configuration byte |
| attempt_i | input | 1 | One-cycle strobe per password attempt |
| pass_ok_i | input | 1 | Attempt outcome, 1 = correct password |
| lim_we_i | input | 1 | Limit register write enable |
| lim_wdata_i | input | 8 | Limit register write value |
| cnt_we_i | input | 1 | Counter write enable |
| cnt_wdata_i | input | 8 | Counter write value |
| full_grant_o | output | 1 | Read/write access allowed |
| cfg_grant_o | output | 1 | Configuration access allowed |
| retry_cnt_o | output | 8 | Present counter value |

## Verification
A run of wrong passwords climbs from zero to a small limit. Further attempts are then made at the limit, which tells a check made before the update apart from one made after it. The same locked state is viewed under every UA1,UA2 combination, with reserved bits toggled, so that total and configuration-only lockout are separated and any decode leak of a reserved bit shows up. Correct passwords are applied with clear-on-pass set and clear, and a 255 counter is pushed to wrap. A counter started above the limit is driven through a 254-failure sweep, which shows that the counter wraps rather than saturating.

// File: rtl/retry_pkg.sv
package retry_pkg;
  localparam int unsigned RL_CFG_W   = 8;
  localparam int unsigned RL_UA1_BIT = 7;
  localparam int unsigned RL_UA2_BIT = 6;
  localparam int unsigned RL_CLR_BIT = 3;
  localparam int unsigned RL_EN_BIT  = 2;

  typedef struct packed {
    logic lock_total;   // UA1,UA2 == 1,0
    logic clr_on_pass;
    logic cnt_en;
  } rl_cfg_t;

  // {full, cfg}
  typedef enum logic [1:0] {
    RL_SHUT     = 2'b00,
    RL_CFG_ONLY = 2'b01,
    RL_OPEN     = 2'b11
  } rl_access_e;
endpackage

// File: rtl/retry_cfg_decode.sv
module retry_cfg_decode
  import retry_pkg::*;
(
  input  logic [RL_CFG_W-1:0] cfg_byte,
  output rl_cfg_t             cfg
);
  localparam logic [RL_CFG_W-1:0] USED_MASK =
    RL_CFG_W'((1 << RL_UA1_BIT) | (1 << RL_UA2_BIT) | (1 << RL_CLR_BIT) | (1 << RL_EN_BIT));

  logic unused_rsvd;
  assign unused_rsvd = ^(cfg_byte & ~USED_MASK);

  always_comb begin
    cfg.lock_total  = cfg_byte[RL_UA1_BIT] & ~cfg_byte[RL_UA2_BIT];
    cfg.clr_on_pass = cfg_byte[RL_CLR_BIT];
    cfg.cnt_en      = cfg_byte[RL_EN_BIT];
  end
endmodule

// File: rtl/retry_limit_cmp.sv
module retry_limit_cmp
  import retry_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] lim,
  input  rl_cfg_t          cfg,
  output logic             at_limit,
  output rl_access_e       access,
  output logic             full_grant,
  output logic             cfg_grant
);
  function automatic rl_access_e decide_access(input logic hit, input logic total);
    if (!hit)       return RL_OPEN;
    else if (total) return RL_SHUT;
    else            return RL_CFG_ONLY;
  endfunction

  assign at_limit   = cfg.cnt_en && (cnt == lim);
  assign access     = decide_access(at_limit, cfg.lock_total);
  assign full_grant = access[1];
  assign cfg_grant  = access[0];

  // R4: below or above the limit both grants stay open
  a_r4_open_off_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cnt_en && cnt != lim) |-> (full_grant && cfg_grant));
  // R5: total lockout
  a_r5_total_shut: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cnt_en && cnt == lim && cfg.lock_total) |-> (!full_grant && !cfg_grant));
  // R6: configuration-only lockout
  a_r6_cfg_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cnt_en && cnt == lim && !cfg.lock_total) |-> (!full_grant && cfg_grant));
  // R3: disabled counting never locks
  a_r3_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.cnt_en |-> (full_grant && cfg_grant));
endmodule

// File: rtl/retry_count_regs.sv
module retry_count_regs
  import retry_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rl_cfg_t          cfg,
  input  logic             at_limit,
  input  logic             attempt,
  input  logic             pass_ok,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic ok, input logic clr);
    if (!ok)     return cur + ONE;
    else if (clr) return '0;
    else          return cur;
  endfunction

  logic ev_counted;   // attempt accepted and applied
  logic ev_blocked;   // attempt refused at the limit
  logic ev_fail;
  logic ev_pass_clr;
  logic [CNT_W-1:0] cnt_d;

  assign ev_counted  = attempt && cfg.cnt_en && !at_limit && !cnt_we;
  assign ev_blocked  = attempt && at_limit;
  assign ev_fail     = ev_counted && !pass_ok;
  assign ev_pass_clr = ev_counted && pass_ok && cfg.clr_on_pass;

  always_comb begin
    cnt_d = cnt;
    if (cnt_we)          cnt_d = cnt_wdata;
    else if (ev_counted) cnt_d = next_count(cnt, pass_ok, cfg.clr_on_pass);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else begin
      cnt <= cnt_d;
      if (lim_we) lim <= lim_wdata;
    end
  end

  // R7: wrong password steps the counter, modulo 2^CNT_W
  a_r7_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> cnt == CNT_W'($past(cnt) + ONE));
  // R8: correct password with clear-on-pass empties the counter
  a_r8_pass_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass_clr |=> cnt == '0);
  // R8: correct password without clear-on-pass keeps it
  a_r8_pass_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt && pass_ok && cfg.cnt_en && !cfg.clr_on_pass && !cnt_we) |=> $stable(cnt));
  // R9: attempt at the limit changes nothing
  a_r9_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_blocked && !cnt_we) |=> $stable(cnt));
  // R3: disabled counting ignores attempts
  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt && !cfg.cnt_en && !cnt_we) |=> $stable(cnt));
  // R10: writes land on the next edge
  a_r10_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt == $past(cnt_wdata));
  a_r10_lim_write: assert property (@(posedge clk) disable iff (!rst_n)
    lim_we |=> lim == $past(lim_wdata));
endmodule

// File: rtl/retry_lockout.sv
module retry_lockout
  import retry_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RL_CFG_W-1:0] cfg_byte_i,
  input  logic                attempt_i,
  input  logic                pass_ok_i,
  input  logic                lim_we_i,
  input  logic [CNT_W-1:0]    lim_wdata_i,
  input  logic                cnt_we_i,
  input  logic [CNT_W-1:0]    cnt_wdata_i,
  output logic                full_grant_o,
  output logic                cfg_grant_o,
  output logic [CNT_W-1:0]    retry_cnt_o
);
  rl_cfg_t          cfg;
  logic             at_limit;
  rl_access_e       access;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  retry_cfg_decode u_dec (
    .cfg_byte (cfg_byte_i),
    .cfg      (cfg)
  );

  retry_limit_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .lim        (lim),
    .cfg        (cfg),
    .at_limit   (at_limit),
    .access     (access),
    .full_grant (full_grant_o),
    .cfg_grant  (cfg_grant_o)
  );

  retry_count_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .at_limit  (at_limit),
    .attempt   (attempt_i),
    .pass_ok   (pass_ok_i),
    .lim_we    (lim_we_i),
    .lim_wdata (lim_wdata_i),
    .cnt_we    (cnt_we_i),
    .cnt_wdata (cnt_wdata_i),
    .cnt       (cnt),
    .lim       (lim)
  );

  assign retry_cnt_o = cnt;

  // R6/R5: full access is never granted without configuration access
  a_r6_grant_order: assert property (@(posedge clk) disable iff (!rst_n)
    full_grant_o |-> cfg_grant_o);
  // R1: counter is zero on the first edge after reset
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (retry_cnt_o == '0 || $past(cnt_we_i)));
endmodule

// File: tb/retry_lockout_tb.sv
`timescale 1ns/1ps
module retry_lockout_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic       attempt = 1'b0, pass_ok = 1'b0;
  logic       lim_we = 1'b0, cnt_we = 1'b0;
  logic [7:0] lim_wdata = 8'h00, cnt_wdata = 8'h00;
  logic       full_g, cfg_g;
  logic [7:0] cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] cnt;
    logic       full;
    logic       cfgg;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_cnt = 8'h00;
  logic [7:0] m_lim = 8'h00;

  always #2.5 clk = ~clk;

  retry_lockout u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte_i(cfg_byte),
    .attempt_i(attempt), .pass_ok_i(pass_ok),
    .lim_we_i(lim_we), .lim_wdata_i(lim_wdata),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .full_grant_o(full_g), .cfg_grant_o(cfg_g), .retry_cnt_o(cnt_o)
  );

  task automatic check(input string tag, input logic [7:0] a_cnt, input logic a_f, input logic a_c,
                       input logic [7:0] e_cnt, input logic e_f, input logic e_c);
    checks++;
    if (a_cnt !== e_cnt || a_f !== e_f || a_c !== e_c) begin
      errors++;
      $display("FAIL %s: actual cnt=%0d full=%b cfg=%b expected cnt=%0d full=%b cfg=%b",
               tag, a_cnt, a_f, a_c, e_cnt, e_f, e_c);
    end
  endtask

  // bench's own reading of the grant rules
  function automatic logic [1:0] grants(input logic [7:0] cb, input logic [7:0] c, input logic [7:0] l);
    logic stuck, total;
    stuck = cb[2] && (c == l);
    total = cb[7] && !cb[6];
    return {!stuck, !stuck || !total};
  endfunction

  // driver: drive at negedge, update model, push expectation
  task automatic step(input logic [7:0] cb, input logic att, input logic ok,
                      input logic lwe, input logic [7:0] lv,
                      input logic cwe, input logic [7:0] cv, input string tag);
    logic [1:0] g;
    @(negedge clk);
    cfg_byte = cb; attempt = att; pass_ok = ok;
    lim_we = lwe; lim_wdata = lv; cnt_we = cwe; cnt_wdata = cv;
    if (cwe) m_cnt = cv;
    else if (att && cb[2] && m_cnt != m_lim) begin
      if (!ok) m_cnt = m_cnt + 8'd1;
      else if (cb[3]) m_cnt = 8'd0;
    end
    if (lwe) m_lim = lv;
    g = grants(cb, m_cnt, m_lim);
    sb.push_back('{m_cnt, g[1], g[0], tag});
  endtask

  task automatic idle(input logic [7:0] cb, input string tag);
    step(cb, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, cnt_o, full_g, cfg_g, e.cnt, e.full, e.cfgg);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL all: watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cfg_byte = 8'h04;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: counter and limit zero, so enabled counting is at its limit
    check("R1 reset", cnt_o, full_g, cfg_g, 8'd0, 1'b0, 1'b1);

    // R3: disabled counting is open and ignores attempts
    idle(8'h00, "R3 open");
    step(8'h00, 1, 0, 0, 0, 0, 0, "R3 wrong ignored");
    step(8'h00, 1, 0, 0, 0, 0, 0, "R3 wrong ignored");

    // R10: limit write, then R4 open
    step(8'h04, 0, 0, 1, 8'd3, 0, 0, "R10 limit write");
    step(8'h04, 1, 0, 0, 0, 0, 0, "R7 fail 1");
    step(8'h04, 1, 0, 0, 0, 0, 0, "R7 fail 2");
    idle(8'h04, "R4 open below limit");
    step(8'h04, 1, 0, 0, 0, 0, 0, "R7 fail reaches limit R6");
    // R9: blocked attempts, wrong and correct
    step(8'h04, 1, 0, 0, 0, 0, 0, "R9 blocked wrong");
    step(8'h0C, 1, 1, 0, 0, 0, 0, "R9 blocked correct");
    // R5 / R6 across UA settings
    idle(8'h84, "R5 total lockout");
    idle(8'hC4, "R6 ua 11");
    idle(8'h44, "R6 ua 01");
    idle(8'h04, "R6 ua 00");
    // R2: reserved bits have no effect
    idle(8'hB7, "R2 reserved with total");
    idle(8'h37, "R2 reserved with cfg-only");
    idle(8'h33, "R2 reserved, disabled");

    // R8: correct password with and without clear
    step(8'h04, 0, 0, 0, 0, 1, 8'd2, "R10 counter write");
    step(8'h04, 1, 1, 0, 0, 0, 0, "R8 keep");
    step(8'h0C, 1, 1, 0, 0, 0, 0, "R8 clear");
    // R10: counter write wins over attempt
    step(8'h04, 1, 0, 0, 0, 1, 8'd1, "R10 write beats attempt");

    // R7 wrap 255 -> 0
    step(8'h04, 0, 0, 1, 8'd10, 1, 8'd255, "R10 setup wrap");
    step(8'h04, 1, 0, 0, 0, 0, 0, "R7 wrap to zero");

    // R11: counter above limit needs 256-(12-10)=254 failures
    step(8'h84, 0, 0, 0, 0, 1, 8'd12, "R11 setup");
    for (int i = 0; i < 254; i++)
      step(8'h84, 1, 0, 0, 0, 0, 0, "R11 sweep");
    idle(8'h84, "R11 idle");
    @(negedge clk);
    // R11: exactly at the limit after 254 failures, total lockout
    check("R11 final", cnt_o, full_g, cfg_g, 8'd10, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule